// File: doc/BRIEF.md
# Timer Tick Source Selector

This block decides when a general-purpose up-counter advances. Control fields choose the counting clock. The internal clock can advance the counter once per cycle. A selected trigger input can advance it once per active edge. A dedicated external-trigger path can also take over, whatever the mode field says. The design produces a single-cycle count-enable pulse, and everything runs on the one internal clock.

Two timer inputs, one external trigger line and up to four internal trigger lines feed a front end. In that front end, each timer input and the external trigger pass through a programmable digital glitch filter. The second timer input is admitted only when its routing field selects it, and a polarity bit picks the edge that counts. A trigger multiplexer and a mode selector then turn the filtered levels into the tick. The counter has a run enable and a software reload strobe. All inputs are taken to be synchronous to the clock already.

Top module: `timer_tick_source`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `count` is 0 and `tick` is 0.
- R2: With `ext_mode`=0 and `slave_mode`=000, `tick` is high on every cycle in which `run`=1, and `count` advances by one per clock; with `run`=0, `count` holds.
- R3: `reload`=1 at a clock edge sets `count` to 0 at that edge, taking precedence over any tick.
- R4: `count` wraps from all ones (0xFFFF at the default width) to 0 on the next tick.
- R5: With `ext_mode`=0 and `slave_mode`=111, `count` advances once per active edge of the selected trigger and is not advanced by the internal clock.
- R6: `trig_sel` encodings: 000 to 011 take the rising edge of `int_trig[trig_sel[1:0]]`; 100 takes either edge of filtered `tin_a`; 101 takes the rising edge of filtered `tin_a`; 110 takes the active edge of filtered channel B; 111 takes the rising edge of filtered `ext_trig`.
- R7: Channel B carries `tin_b` only when `route_b`=01; for any other value the channel-B path is held low and produces no edges.
- R8: `invert_b`=0 makes the rising edge of filtered channel B active; `invert_b`=1 makes the falling edge active.
- R9: A filter length field of 0 makes the filtered level follow its input one clock later. A value N>0 changes the filtered level only after the input has shown the new level for N+1 consecutive clocks. `flt_len` applies to `tin_a` and `tin_b`, and `ext_flt_len` applies to `ext_trig`.
- R10: With `ext_mode`=1, `count` advances once per rising edge of filtered `ext_trig`, whatever `slave_mode` and `trig_sel` hold.
- R11: With `ext_mode`=0 and `slave_mode` other than 000 or 111, `count` does not advance.
- R12: `tick` is high for exactly one cycle per detected edge. `count` advances at exactly the clock edges where `tick` was high, so the new value appears one clock after `tick` rises.
- R13: With `run`=0, `tick` stays low and `count` does not advance in any mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Counter run enable |
| reload | input | 1 | Software reload strobe, clears the counter |
| slave_mode | input | 3 | 000 internal clock, 111 trigger-edge counting |
| trig_sel | input | 3 | Trigger source select |
| ext_mode | input | 1 | Count on filtered external-trigger edges, overriding slave_mode |
| route_b | input | 2 | Channel-B routing, 01 connects tin_b |
| invert_b | input | 1 | Channel-B active edge, 0 rising, 1 falling |
| flt_len | input | FLT_W | Filter length for tin_a and tin_b |
| ext_flt_len | input | FLT_W | Filter length for ext_trig |
| tin_a | input | 1 | Timer input A |
| tin_b | input | 1 | Timer input B |
| ext_trig | input | 1 | External trigger line |
| int_trig | input | NUM_ITRIG | Internal trigger lines |
| tick | output | 1 | Count-enable pulse |
| count | output | CNT_W | Counter value |

## Verification
The bench builds the block with its defaults: a 16-bit counter, 4-bit filter length fields and four internal trigger lines. At 16 bits the wrap from 0xFFFF to 0 is reached in about 65,536 internal-clock cycles. The 4-bit filter fields put the longest filter setting (15, needing 16 steady clocks) within reach, along with its off-by-one neighbour. Each trigger encoding, the polarity choice, the channel-B routing and the override by the external path are driven with pulse trains whose edge counts are known in advance.

// File: rtl/tts_pkg.sv
package tts_pkg;
    localparam logic [2:0] SLV_OFF     = 3'b000;
    localparam logic [2:0] SLV_EDGE    = 3'b111;
    localparam logic [2:0] TSEL_A_BOTH = 3'b100;
    localparam logic [2:0] TSEL_A_RISE = 3'b101;
    localparam logic [2:0] TSEL_B      = 3'b110;
    localparam logic [2:0] TSEL_EXT    = 3'b111;
    localparam logic [1:0] ROUTE_B_DIRECT = 2'b01;
    localparam int         IT_SLOTS    = 4;

    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_INTCLK = 2'd1,
        SRC_TRIG   = 2'd2,
        SRC_EXT    = 2'd3
    } src_e;
endpackage

// File: rtl/tts_glitch_filter.sv
module tts_glitch_filter #(
    parameter int FLT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             din,
    input  logic [FLT_W-1:0] len,
    output logic             dout
);
    typedef struct packed {
        logic             lvl;
        logic [FLT_W-1:0] run;
    } flt_t;

    flt_t flt_q, flt_d;

    always_comb begin
        flt_d = flt_q;
        if (din == flt_q.lvl) begin
            flt_d.run = '0;
        end else if (flt_q.run >= len) begin
            flt_d.lvl = din;
            flt_d.run = '0;
        end else begin
            flt_d.run = flt_q.run + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flt_q <= '0;
        else        flt_q <= flt_d;
    end

    assign dout = flt_q.lvl;

    // R9
    lvl_follows_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(flt_q.lvl) |-> flt_q.lvl == $past(din));

    // R9
    zero_len_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (len == '0 && din != flt_q.lvl) |=> flt_q.lvl == $past(din));
endmodule

// File: rtl/tts_trig_front.sv
module tts_trig_front #(
    parameter int FLT_W     = 4,
    parameter int NUM_ITRIG = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tin_a,
    input  logic                 tin_b,
    input  logic                 ext_trig,
    input  logic [NUM_ITRIG-1:0] int_trig,
    input  logic [1:0]           route_b,
    input  logic [FLT_W-1:0]     flt_len,
    input  logic [FLT_W-1:0]     ext_flt_len,
    output logic                 a_lvl,
    output logic                 b_lvl,
    output logic                 e_lvl,
    output logic [NUM_ITRIG-1:0] it_lvl
);
    import tts_pkg::*;

    typedef struct packed {
        logic [NUM_ITRIG-1:0] it;
    } front_t;

    front_t front_q, front_d;
    logic   b_raw;

    always_comb begin
        b_raw       = (route_b == ROUTE_B_DIRECT) ? tin_b : 1'b0;
        front_d     = front_q;
        front_d.it  = int_trig;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) front_q <= '0;
        else        front_q <= front_d;
    end

    assign it_lvl = front_q.it;

    tts_glitch_filter #(.FLT_W(FLT_W)) u_flt_a (
        .clk (clk), .rst_n (rst_n), .din (tin_a), .len (flt_len), .dout (a_lvl)
    );

    tts_glitch_filter #(.FLT_W(FLT_W)) u_flt_b (
        .clk (clk), .rst_n (rst_n), .din (b_raw), .len (flt_len), .dout (b_lvl)
    );

    tts_glitch_filter #(.FLT_W(FLT_W)) u_flt_e (
        .clk (clk), .rst_n (rst_n), .din (ext_trig), .len (ext_flt_len), .dout (e_lvl)
    );

    // R7
    route_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (route_b != ROUTE_B_DIRECT && !b_lvl) |=> !b_lvl);
endmodule

// File: rtl/tts_tick_select.sv
module tts_tick_select #(
    parameter int NUM_ITRIG = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run,
    input  logic [2:0]           slave_mode,
    input  logic [2:0]           trig_sel,
    input  logic                 ext_mode,
    input  logic                 invert_b,
    input  logic                 a_lvl,
    input  logic                 b_lvl,
    input  logic                 e_lvl,
    input  logic [NUM_ITRIG-1:0] it_lvl,
    output logic                 tick
);
    import tts_pkg::*;

    typedef struct packed {
        logic                 a;
        logic                 b;
        logic                 e;
        logic [NUM_ITRIG-1:0] it;
    } prev_t;

    prev_t             prev_q, prev_d;
    logic [IT_SLOTS-1:0] it_rise_all;
    logic              a_rise, a_fall, b_rise, b_fall, e_rise;
    logic              trig_edge;
    src_e              src;

    for (genvar g = 0; g < IT_SLOTS; g++) begin : g_it
        if (g < NUM_ITRIG) begin : g_live
            assign it_rise_all[g] = it_lvl[g] & ~prev_q.it[g];
        end else begin : g_tied
            assign it_rise_all[g] = 1'b0;
        end
    end

    always_comb begin
        a_rise = a_lvl & ~prev_q.a;
        a_fall = ~a_lvl & prev_q.a;
        b_rise = b_lvl & ~prev_q.b;
        b_fall = ~b_lvl & prev_q.b;
        e_rise = e_lvl & ~prev_q.e;

        unique case (trig_sel)
            TSEL_A_BOTH: trig_edge = a_rise | a_fall;
            TSEL_A_RISE: trig_edge = a_rise;
            TSEL_B:      trig_edge = invert_b ? b_fall : b_rise;
            TSEL_EXT:    trig_edge = e_rise;
            default:     trig_edge = it_rise_all[trig_sel[1:0]];
        endcase

        if (ext_mode)                    src = SRC_EXT;
        else if (slave_mode == SLV_OFF)  src = SRC_INTCLK;
        else if (slave_mode == SLV_EDGE) src = SRC_TRIG;
        else                             src = SRC_NONE;

        unique case (src)
            SRC_INTCLK: tick = run;
            SRC_TRIG:   tick = run & trig_edge;
            SRC_EXT:    tick = run & e_rise;
            default:    tick = 1'b0;
        endcase

        prev_d    = prev_q;
        prev_d.a  = a_lvl;
        prev_d.b  = b_lvl;
        prev_d.e  = e_lvl;
        prev_d.it = it_lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    // R11
    idle_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_mode && slave_mode != SLV_OFF && slave_mode != SLV_EDGE) |-> !tick);

    // R13
    halted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !tick);

    // R10
    ext_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && ext_mode) |=> !(tick && ext_mode));

    // R10
    ext_needs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && ext_mode) |-> e_lvl);
endmodule

// File: rtl/tts_up_counter.sv
module tts_up_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             reload,
    output logic [CNT_W-1:0] count
);
    typedef struct packed {
        logic [CNT_W-1:0] val;
    } cnt_t;

    cnt_t cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (reload)    cnt_d.val = '0;
        else if (tick) cnt_d.val = cnt_q.val + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q.val;

    // R12
    advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !reload) |=> count == $past(count) + 1'b1);

    // R12
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !reload) |=> $stable(count));

    // R3
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> count == '0);

    // R4
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !reload && count == {CNT_W{1'b1}}) |=> count == '0);
endmodule

// File: rtl/timer_tick_source.sv
module timer_tick_source #(
    parameter int CNT_W     = 16,
    parameter int FLT_W     = 4,
    parameter int NUM_ITRIG = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run,
    input  logic                 reload,
    input  logic [2:0]           slave_mode,
    input  logic [2:0]           trig_sel,
    input  logic                 ext_mode,
    input  logic [1:0]           route_b,
    input  logic                 invert_b,
    input  logic [FLT_W-1:0]     flt_len,
    input  logic [FLT_W-1:0]     ext_flt_len,
    input  logic                 tin_a,
    input  logic                 tin_b,
    input  logic                 ext_trig,
    input  logic [NUM_ITRIG-1:0] int_trig,
    output logic                 tick,
    output logic [CNT_W-1:0]     count
);
    logic                 a_lvl, b_lvl, e_lvl;
    logic [NUM_ITRIG-1:0] it_lvl;

    tts_trig_front #(.FLT_W(FLT_W), .NUM_ITRIG(NUM_ITRIG)) u_front (
        .clk         (clk),
        .rst_n       (rst_n),
        .tin_a       (tin_a),
        .tin_b       (tin_b),
        .ext_trig    (ext_trig),
        .int_trig    (int_trig),
        .route_b     (route_b),
        .flt_len     (flt_len),
        .ext_flt_len (ext_flt_len),
        .a_lvl       (a_lvl),
        .b_lvl       (b_lvl),
        .e_lvl       (e_lvl),
        .it_lvl      (it_lvl)
    );

    tts_tick_select #(.NUM_ITRIG(NUM_ITRIG)) u_select (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .slave_mode (slave_mode),
        .trig_sel   (trig_sel),
        .ext_mode   (ext_mode),
        .invert_b   (invert_b),
        .a_lvl      (a_lvl),
        .b_lvl      (b_lvl),
        .e_lvl      (e_lvl),
        .it_lvl     (it_lvl),
        .tick       (tick)
    );

    tts_up_counter #(.CNT_W(CNT_W)) u_counter (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .reload (reload),
        .count  (count)
    );
endmodule

// File: tb/timer_tick_source_test.sv
module timer_tick_source_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        run, reload, ext_mode, invert_b;
    logic [2:0]  slave_mode, trig_sel;
    logic [1:0]  route_b;
    logic [3:0]  flt_len, ext_flt_len;
    logic        tin_a, tin_b, ext_trig;
    logic [3:0]  int_trig;
    logic        tick;
    logic [15:0] count;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    int          kind_q[$];
    logic [15:0] val_q[$];
    string       tag_q[$];
    event        chk_ev;

    always #5 clk = ~clk;

    timer_tick_source uut (
        .clk (clk), .rst_n (rst_n), .run (run), .reload (reload),
        .slave_mode (slave_mode), .trig_sel (trig_sel), .ext_mode (ext_mode),
        .route_b (route_b), .invert_b (invert_b), .flt_len (flt_len),
        .ext_flt_len (ext_flt_len), .tin_a (tin_a), .tin_b (tin_b),
        .ext_trig (ext_trig), .int_trig (int_trig), .tick (tick), .count (count)
    );

    // monitor: pops expected items and compares with the outputs
    initial begin
        forever begin
            @(chk_ev);
            while (val_q.size() > 0) begin
                automatic int          k = kind_q.pop_front();
                automatic logic [15:0] v = val_q.pop_front();
                automatic string       t = tag_q.pop_front();
                checks++;
                if (k == 0 && count !== v) begin
                    failures++;
                    $display("FAIL %s count actual=%0h expected=%0h", t, count, v);
                end else if (k == 1 && tick !== v[0]) begin
                    failures++;
                    $display("FAIL %s tick actual=%0b expected=%0b", t, tick, v[0]);
                end
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    task automatic push_exp(input int k, input logic [15:0] v, input string t);
        kind_q.push_back(k);
        val_q.push_back(v);
        tag_q.push_back(t);
        -> chk_ev;
        #1;
    endtask

    task automatic exp_cnt(input logic [15:0] v, input string t);
        push_exp(0, v, t);
    endtask

    task automatic exp_tick(input logic v, input string t);
        push_exp(1, {15'd0, v}, t);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive_line(input int which, input logic v);
        case (which)
            0: tin_a = v;
            1: tin_b = v;
            2: ext_trig = v;
            3: int_trig[2] = v;
            default: int_trig[1] = v;
        endcase
    endtask

    task automatic pulse(input int which, input int hi, input int lo);
        drive_line(which, 1'b1);
        step(hi);
        drive_line(which, 1'b0);
        step(lo);
    endtask

    task automatic do_reload();
        reload = 1'b1;
        step(1);
        reload = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; run = 1'b0; reload = 1'b0; ext_mode = 1'b0; invert_b = 1'b0;
        slave_mode = 3'b000; trig_sel = 3'b000; route_b = 2'b01;
        flt_len = 4'd0; ext_flt_len = 4'd0;
        tin_a = 1'b0; tin_b = 1'b0; ext_trig = 1'b0; int_trig = 4'd0;
        step(3);
        exp_cnt(16'd0, "R1 in reset");
        rst_n = 1'b1;
        step(1);
        exp_cnt(16'd0, "R1 after reset");
        exp_tick(1'b0, "R1 after reset");

        // R2 internal clock, halted then running
        step(4);
        exp_cnt(16'd0, "R2 hold with run low");
        run = 1'b1;
        step(1);
        exp_cnt(16'd1, "R2 first clock");
        exp_tick(1'b1, "R2 tick every clock");
        step(9);
        exp_cnt(16'd10, "R2 ten clocks");

        // R3 reload beats tick
        do_reload();
        exp_cnt(16'd0, "R3 reload");
        step(3);
        exp_cnt(16'd3, "R3 count after reload");

        // R4 wrap
        do_reload();
        step(65535);
        exp_cnt(16'hFFFF, "R4 all ones");
        step(1);
        exp_cnt(16'h0000, "R4 wrap");
        run = 1'b0;
        step(2);
        exp_cnt(16'h0000, "R2 halt holds");

        // R5 edge mode on channel B rising
        slave_mode = 3'b111; trig_sel = 3'b110; run = 1'b1;
        do_reload();
        step(3);
        exp_cnt(16'd0, "R5 clock alone ignored");
        tin_b = 1'b1;
        step(1);
        exp_tick(1'b1, "R12 tick on edge");
        exp_cnt(16'd0, "R12 count not yet");
        step(1);
        exp_tick(1'b0, "R12 single cycle");
        exp_cnt(16'd1, "R12 count one clock later");
        tin_b = 1'b0;
        step(3);
        pulse(1, 2, 3);
        pulse(1, 2, 3);
        exp_cnt(16'd3, "R5 three edges");

        // R8 falling edge
        invert_b = 1'b1;
        do_reload();
        tin_b = 1'b1;
        step(4);
        exp_cnt(16'd0, "R8 rising ignored");
        tin_b = 1'b0;
        step(3);
        exp_cnt(16'd1, "R8 falling counts");
        pulse(1, 2, 3);
        exp_cnt(16'd2, "R8 second falling");
        invert_b = 1'b0;

        // R9 filter lengths
        flt_len = 4'd3;
        do_reload();
        pulse(1, 3, 6);
        exp_cnt(16'd0, "R9 short glitch rejected");
        pulse(1, 4, 6);
        exp_cnt(16'd1, "R9 N+1 accepted");
        flt_len = 4'd15;
        pulse(1, 15, 20);
        exp_cnt(16'd1, "R9 max length glitch rejected");
        pulse(1, 16, 20);
        exp_cnt(16'd2, "R9 max length accepted");
        flt_len = 4'd0;

        // R7 routing
        route_b = 2'b00;
        do_reload();
        pulse(1, 2, 3);
        pulse(1, 2, 3);
        exp_cnt(16'd0, "R7 route 00 blocks");
        route_b = 2'b11;
        pulse(1, 2, 3);
        exp_cnt(16'd0, "R7 route 11 blocks");
        route_b = 2'b01;

        // R6 input A, rising then both edges
        trig_sel = 3'b101;
        do_reload();
        pulse(0, 2, 3);
        pulse(0, 2, 3);
        exp_cnt(16'd2, "R6 sel 101 rising A");
        pulse(1, 2, 3);
        exp_cnt(16'd2, "R6 B ignored under 101");
        trig_sel = 3'b100;
        do_reload();
        pulse(0, 2, 3);
        pulse(0, 2, 3);
        exp_cnt(16'd4, "R6 sel 100 both edges");

        // R6 internal trigger line 2
        trig_sel = 3'b010;
        do_reload();
        pulse(3, 1, 2);
        pulse(3, 1, 2);
        pulse(3, 1, 2);
        exp_cnt(16'd3, "R6 internal line 2");
        pulse(4, 1, 2);
        exp_cnt(16'd3, "R6 other line ignored");

        // R6 external trigger through trigger select, with its filter
        trig_sel = 3'b111; ext_flt_len = 4'd2;
        do_reload();
        pulse(2, 3, 4);
        pulse(2, 3, 4);
        exp_cnt(16'd2, "R6 sel 111 external");
        pulse(2, 2, 4);
        exp_cnt(16'd2, "R9 external glitch rejected");
        ext_flt_len = 4'd0;

        // R13 halted in edge mode
        trig_sel = 3'b101;
        do_reload();
        run = 1'b0;
        pulse(0, 2, 3);
        pulse(0, 2, 3);
        exp_cnt(16'd0, "R13 no count when halted");
        exp_tick(1'b0, "R13 tick low");
        run = 1'b1;

        // R11 unsupported mode value
        slave_mode = 3'b011;
        do_reload();
        step(5);
        pulse(0, 2, 3);
        exp_cnt(16'd0, "R11 other mode idle");

        // R10 external mode overrides internal clock and trigger select
        slave_mode = 3'b000; ext_mode = 1'b1;
        do_reload();
        step(4);
        exp_cnt(16'd0, "R10 internal clock overridden");
        exp_tick(1'b0, "R10 tick idle");
        pulse(2, 1, 2);
        pulse(2, 1, 2);
        pulse(2, 1, 2);
        exp_cnt(16'd3, "R10 external edges");
        pulse(0, 2, 3);
        exp_cnt(16'd3, "R10 trigger select ignored");
        ext_mode = 1'b0;
        step(2);

        finish_run();
    end
endmodule